// File: doc/BRIEF.md
# Configurable I/O Port Decoder for a Video Display Peripheral

This block sits between an 8-bit CPU's I/O bus and a video display processor. It looks at the low eight address bits and the IORQ, RD, WR and M1 control lines of every bus cycle. When a cycle is an I/O access to the configured port range, it produces an active-low read select or write select. Address bit 0 is not compared: it passes through as a register-select line that picks the data port or the control port of the peripheral.

The port range is set by separate match modes for separate address fields. Bits 7..5 choose one of eight 32-port windows. Bit 4 can be ignored, required 0 or required 1. Bit 3 can be required 1 or ignored. Bits 2..1 can be required 0 or ignored. The peripheral's active-low interrupt request is routed to either a maskable or a non-maskable active-low output, and the unselected output stays released. Three built-in presets cover common host systems. A custom setting takes its fields from the configuration inputs. Every output is registered once on the system clock, so each output reflects the bus inputs of the previous clock edge.

Top module: `iodec_vdp_port`

## Requirements
- R1: A chip select asserts only when address bits 7..5 equal the effective 3-bit window value, so window w answers at ports 32*w to 32*w+31.
- R2: Bit 4 mode encoding: 2'd0 and 2'd3 ignore bit 4, 2'd1 requires bit 4 = 0, 2'd2 requires bit 4 = 1.
- R3: When the bit-3 control is 1, bit 3 must be 1 for a match. When it is 0, bit 3 is ignored.
- R4: When the bits-2..1 control is 1, address bits 2 and 1 must both be 0 for a match. When it is 0, both bits are ignored.
- R5: rd_cs_n_o is low in the cycle after an edge that sampled IORQ low, M1 high, RD low and a matching address. wr_cs_n_o behaves the same way with WR in place of RD. Otherwise both selects are high.
- R6: A cycle with M1 low (interrupt acknowledge) never asserts either select, whatever the address and strobes.
- R7: reg_sel_o equals address bit 0 as sampled at the previous edge. Bit 0 never affects whether the address matches.
- R8: With the routing control at 0, int_n_o follows the interrupt request one cycle later and nmi_n_o stays 1. With the control at 1, the roles swap. The two outputs are never low together.
- R9: preset_i encoding: 0 uses the custom inputs. 1 uses window 4, bit 4 = 1, bit 3 = 1, bits 2..1 = 0, maskable interrupt, so only ports 98h and 99h match. 2 uses window 5, all low fields ignored, non-maskable interrupt, so A0h to BFh match. 3 uses window 0, bit 4 = 1, bits 3..1 ignored, maskable interrupt, so 10h to 1Fh match. When preset_i is not 0, the custom inputs have no effect.
- R10: While rst_n is low at a clock edge, both selects, int_n_o and nmi_n_o go high and reg_sel_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Low byte of the I/O address |
| iorq_n_i | input | 1 | I/O request, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| m1_n_i | input | 1 | Opcode fetch / acknowledge marker, active low |
| preset_i | input | 2 | Host preset select (0 = custom) |
| win_i | input | 3 | Custom window value for bits 7..5 |
| b4_mode_i | input | 2 | Custom bit-4 match mode |
| b3_must1_i | input | 1 | Custom: bit 3 must be 1 |
| b21_must0_i | input | 1 | Custom: bits 2..1 must be 0 |
| irq_to_nmi_i | input | 1 | Custom interrupt routing (1 = non-maskable) |
| vdp_irq_n_i | input | 1 | Peripheral interrupt request, active low |
| rd_cs_n_o | output | 1 | Read chip select, active low |
| wr_cs_n_o | output | 1 | Write chip select, active low |
| reg_sel_o | output | 1 | Register select (address bit 0) |
| int_n_o | output | 1 | Maskable interrupt, active low, released high |
| nmi_n_o | output | 1 | Non-maskable interrupt, active low, released high |

## Verification
A port access and an interrupt request can land on the same clock edge, and the chip-select path must not disturb the interrupt path, nor the reverse. The bench toggles the interrupt request in a fixed pattern while it sweeps every port address with read and write cycles under each preset and several custom settings. It compares every output, each clock, against a behavioural model of the decode and routing rules. Acknowledge cycles with M1 low are also issued while the request is active. In those cycles the selects must stay high and the routed interrupt must still follow the request.

// File: rtl/iodec_pkg.sv
// Package: shared widths, mode encodings and the configuration record
// used by the I/O port decoder. Assumes an 8-bit I/O address.
package iodec_pkg;
    localparam int IODEC_ADDR_W = 8;
    localparam int IODEC_WIN_W  = 3;
    localparam int IODEC_PRE_W  = 2;

    // Match mode for address bit 4; two codes mean "ignore"
    typedef enum logic [1:0] {
        B4_ANY  = 2'd0,
        B4_ZERO = 2'd1,
        B4_ONE  = 2'd2,
        B4_ANYX = 2'd3
    } b4_mode_e;

    // Host preset selection
    typedef enum logic [IODEC_PRE_W-1:0] {
        PRE_CUSTOM = 2'd0,
        PRE_HOST_A = 2'd1,
        PRE_HOST_B = 2'd2,
        PRE_HOST_C = 2'd3
    } preset_e;

    // Effective decode configuration
    typedef struct packed {
        logic [IODEC_WIN_W-1:0] win;
        b4_mode_e               b4;
        logic                   b3_must1;
        logic                   b21_must0;
        logic                   irq_nmi;
    } dec_cfg_t;
endpackage

// File: rtl/iodec_cfg_mux.sv
// Module: iodec_cfg_mux
// Resolves the effective decode configuration: either one of three fixed
// host presets or the custom configuration inputs. Purely combinational;
// assumes the configuration inputs are static during bus activity.
module iodec_cfg_mux
    import iodec_pkg::*;
#(
    parameter int WIN_W = IODEC_WIN_W,
    parameter int PRE_W = IODEC_PRE_W
) (
    input  logic [PRE_W-1:0] preset_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic [1:0]       b4_mode_i,
    input  logic             b3_must1_i,
    input  logic             b21_must0_i,
    input  logic             irq_to_nmi_i,
    output dec_cfg_t         cfg_o
);
    localparam logic [WIN_W-1:0] WIN_A = WIN_W'(4);
    localparam logic [WIN_W-1:0] WIN_B = WIN_W'(5);
    localparam logic [WIN_W-1:0] WIN_C = WIN_W'(0);

    // Select preset fields or pass the custom fields through
    always_comb begin
        cfg_o = '0;
        case (preset_e'(preset_i))
            PRE_HOST_A: begin
                cfg_o.win       = WIN_A;
                cfg_o.b4        = B4_ONE;
                cfg_o.b3_must1  = 1'b1;
                cfg_o.b21_must0 = 1'b1;
                cfg_o.irq_nmi   = 1'b0;
            end
            PRE_HOST_B: begin
                cfg_o.win       = WIN_B;
                cfg_o.b4        = B4_ANY;
                cfg_o.b3_must1  = 1'b0;
                cfg_o.b21_must0 = 1'b0;
                cfg_o.irq_nmi   = 1'b1;
            end
            PRE_HOST_C: begin
                cfg_o.win       = WIN_C;
                cfg_o.b4        = B4_ONE;
                cfg_o.b3_must1  = 1'b0;
                cfg_o.b21_must0 = 1'b0;
                cfg_o.irq_nmi   = 1'b0;
            end
            default: begin
                cfg_o.win       = win_i;
                cfg_o.b4        = b4_mode_e'(b4_mode_i);
                cfg_o.b3_must1  = b3_must1_i;
                cfg_o.b21_must0 = b21_must0_i;
                cfg_o.irq_nmi   = irq_to_nmi_i;
            end
        endcase
    end
endmodule

// File: rtl/iodec_addr_match.sv
// Module: iodec_addr_match
// Compares address bits ADDR_W-1..1 with the effective configuration,
// one field at a time, and ANDs the field results. Bit 0 is not an input:
// it never takes part in the match. Combinational.
module iodec_addr_match
    import iodec_pkg::*;
#(
    parameter int ADDR_W = IODEC_ADDR_W,
    parameter int WIN_W  = IODEC_WIN_W
) (
    input  logic [ADDR_W-1:1] addr_i,
    input  dec_cfg_t          cfg_i,
    output logic              match_o
);
    localparam int WIN_LSB = ADDR_W - WIN_W;  // lowest window bit (5)
    localparam int B4_POS  = WIN_LSB - 1;     // single-mode bit (4)
    localparam int B3_POS  = B4_POS - 1;      // must-be-1 bit (3)
    localparam int LOW_HI  = B3_POS - 1;      // top of must-be-0 field (2)
    localparam int LOW_N   = LOW_HI;          // bits LOW_HI..1

    logic win_hit, b4_hit, b3_hit, low_hit;
    logic [LOW_N-1:0] low_bit_ok;

    // Window field: exact compare of the top bits
    always_comb win_hit = (addr_i[ADDR_W-1:WIN_LSB] == cfg_i.win);

    // Bit 4 field: three-way mode
    always_comb begin
        case (cfg_i.b4)
            B4_ZERO: b4_hit = ~addr_i[B4_POS];
            B4_ONE:  b4_hit =  addr_i[B4_POS];
            default: b4_hit = 1'b1;
        endcase
    end

    // Bit 3 field: must be 1 or ignored
    always_comb b3_hit = ~cfg_i.b3_must1 | addr_i[B3_POS];

    // Low field: each bit must be 0 when the mode demands it
    for (genvar g = 0; g < LOW_N; g++) begin : g_low
        always_comb low_bit_ok[g] = ~cfg_i.b21_must0 | ~addr_i[g+1];
    end
    always_comb low_hit = &low_bit_ok;

    // Combine the field results
    always_comb match_o = win_hit & b4_hit & b3_hit & low_hit;
endmodule

// File: rtl/iodec_strobe_gen.sv
// Module: iodec_strobe_gen
// Qualifies the address match with the bus control lines and registers
// the read/write selects and the register-select bit. Acknowledge cycles
// (M1 low) are never decoded. Synchronous active-low reset.
module iodec_strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic iorq_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    input  logic m1_n_i,
    input  logic addr0_i,
    output logic rd_cs_n_o,
    output logic wr_cs_n_o,
    output logic reg_sel_o
);
    logic io_cycle;

    // A plain I/O cycle aimed at this device
    always_comb io_cycle = ~iorq_n_i & m1_n_i & match_i;

    // Register the selects and the register-select bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cs_n_o <= 1'b1;
            wr_cs_n_o <= 1'b1;
            reg_sel_o <= 1'b0;
        end else begin
            rd_cs_n_o <= ~(io_cycle & ~rd_n_i);
            wr_cs_n_o <= ~(io_cycle & ~wr_n_i);
            reg_sel_o <= addr0_i;
        end
    end

    // A select may only follow an edge that saw IORQ low
    assert_cs_needs_iorq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cs_n_o || !wr_cs_n_o) |-> $past(!iorq_n_i));
    // Acknowledge cycles are never decoded
    assert_no_ack_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cs_n_o || !wr_cs_n_o) |-> $past(m1_n_i));
endmodule

// File: rtl/iodec_irq_route.sv
// Module: iodec_irq_route
// Steers the peripheral's active-low interrupt request to the maskable or
// the non-maskable output. Outputs model open-drain pulls: 1 means
// released. Registered, synchronous active-low reset.
module iodec_irq_route (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    input  logic to_nmi_i,
    output logic int_n_o,
    output logic nmi_n_o
);
    // Drive only the selected line; hold the other released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_n_o <= 1'b1;
            nmi_n_o <= 1'b1;
        end else begin
            int_n_o <= irq_n_i | to_nmi_i;
            nmi_n_o <= irq_n_i | ~to_nmi_i;
        end
    end

    // Never pull both interrupt lines at once
    assert_irq_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_n_o || nmi_n_o));
    // A pulled line always traces back to an active request
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n_o || !nmi_n_o) |-> $past(!irq_n_i));
endmodule

// File: rtl/iodec_vdp_port.sv
// Module: iodec_vdp_port (top)
// I/O port decoder for a video display peripheral: resolves the host
// configuration, matches the address, generates registered selects and
// routes the interrupt. Assumes configuration is static while in use.
module iodec_vdp_port
    import iodec_pkg::*;
#(
    parameter int ADDR_W = IODEC_ADDR_W,
    parameter int WIN_W  = IODEC_WIN_W,
    parameter int PRE_W  = IODEC_PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              iorq_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              m1_n_i,
    input  logic [PRE_W-1:0]  preset_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [1:0]        b4_mode_i,
    input  logic              b3_must1_i,
    input  logic              b21_must0_i,
    input  logic              irq_to_nmi_i,
    input  logic              vdp_irq_n_i,
    output logic              rd_cs_n_o,
    output logic              wr_cs_n_o,
    output logic              reg_sel_o,
    output logic              int_n_o,
    output logic              nmi_n_o
);
    localparam int WIN_LSB = ADDR_W - WIN_W;

    dec_cfg_t cfg;
    logic     match;

    iodec_cfg_mux #(.WIN_W(WIN_W), .PRE_W(PRE_W)) cfg_i (
        .preset_i     (preset_i),
        .win_i        (win_i),
        .b4_mode_i    (b4_mode_i),
        .b3_must1_i   (b3_must1_i),
        .b21_must0_i  (b21_must0_i),
        .irq_to_nmi_i (irq_to_nmi_i),
        .cfg_o        (cfg)
    );

    iodec_addr_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) match_i (
        .addr_i  (addr_i[ADDR_W-1:1]),
        .cfg_i   (cfg),
        .match_o (match)
    );

    iodec_strobe_gen strobe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_i   (match),
        .iorq_n_i  (iorq_n_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .m1_n_i    (m1_n_i),
        .addr0_i   (addr_i[0]),
        .rd_cs_n_o (rd_cs_n_o),
        .wr_cs_n_o (wr_cs_n_o),
        .reg_sel_o (reg_sel_o)
    );

    iodec_irq_route irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n_i  (vdp_irq_n_i),
        .to_nmi_i (cfg.irq_nmi),
        .int_n_o  (int_n_o),
        .nmi_n_o  (nmi_n_o)
    );

    // A select implies the window bits matched at the sampling edge
    assert_window_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cs_n_o || !wr_cs_n_o) |-> ($past(addr_i[ADDR_W-1:WIN_LSB]) == $past(cfg.win)));
    // With the low-field mode on, a select implies bits 2..1 were zero
    assert_low_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cs_n_o && $past(cfg.b21_must0)) |-> ($past(addr_i[2:1]) == 2'b00));
    // With the bit-3 mode on, a select implies bit 3 was one
    assert_bit3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cs_n_o && $past(cfg.b3_must1)) |-> $past(addr_i[3]));
endmodule

// File: tb/iodec_vdp_port_tb.sv
// Bench: drives bus cycles at falling edges, compares every output at the
// next falling edge against a behavioural model of the requirements.
module iodec_vdp_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       iorq_n, rd_n, wr_n, m1_n;
    logic [1:0] preset;
    logic [2:0] win;
    logic [1:0] b4m;
    logic       b3m, b21m, to_nmi, irq_n;
    logic       rd_cs_n, wr_cs_n, reg_sel, int_n, nmi_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected outputs for the next compare
    logic e_rd, e_wr, e_rs, e_int, e_nmi;

    always #10 clk = ~clk;  // 50 MHz

    iodec_vdp_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .iorq_n_i(iorq_n),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .m1_n_i(m1_n), .preset_i(preset),
        .win_i(win), .b4_mode_i(b4m), .b3_must1_i(b3m), .b21_must0_i(b21m),
        .irq_to_nmi_i(to_nmi), .vdp_irq_n_i(irq_n),
        .rd_cs_n_o(rd_cs_n), .wr_cs_n_o(wr_cs_n), .reg_sel_o(reg_sel),
        .int_n_o(int_n), .nmi_n_o(nmi_n)
    );

    // Reference: does port a answer under the current configuration?
    function automatic bit ref_match(int a);
        int w, m4; bit t3, t21, nm;
        case (preset)
            2'd1: begin w = 4; m4 = 2; t3 = 1; t21 = 1; end
            2'd2: begin w = 5; m4 = 0; t3 = 0; t21 = 0; end
            2'd3: begin w = 0; m4 = 2; t3 = 0; t21 = 0; end
            default: begin w = win; m4 = b4m; t3 = b3m; t21 = b21m; end
        endcase
        if (a / 32 != w) return 0;                    // R1
        if (m4 == 1 && ((a / 16) % 2) != 0) return 0; // R2
        if (m4 == 2 && ((a / 16) % 2) != 1) return 0; // R2
        if (t3 && ((a / 8) % 2) == 0) return 0;       // R3
        if (t21 && ((a / 2) % 4) != 0) return 0;      // R4
        return 1;
    endfunction

    function automatic bit ref_nmi();
        case (preset)
            2'd1, 2'd3: return 0;
            2'd2:       return 1;
            default:    return to_nmi;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (addr %02h preset %0d)",
                     tag, what, act, exp, addr, preset);
        end
    endtask

    // Drive one cycle, then compare every output at the next falling edge
    task automatic cyc(input logic [7:0] a, input logic io, input logic r,
                       input logic w, input logic m1, input logic irq, input string tag);
        bit hit;
        addr = a; iorq_n = io; rd_n = r; wr_n = w; m1_n = m1; irq_n = irq;
        hit   = ref_match(int'(a)) && !io && m1;
        e_rd  = !(hit && !r);
        e_wr  = !(hit && !w);
        e_rs  = a[0];
        e_int = irq | ref_nmi();
        e_nmi = irq | ~ref_nmi();
        @(negedge clk);
        chk(tag, "rd_cs_n", rd_cs_n, e_rd);
        chk(tag, "wr_cs_n", wr_cs_n, e_wr);
        chk("R7", "reg_sel", reg_sel, e_rs);
        chk("R8", "int_n", int_n, e_int);
        chk("R8", "nmi_n", nmi_n, e_nmi);
    endtask

    // Full 256-port sweep: read, write, and acknowledge cycle per port
    task automatic sweep(input string tag);
        for (int a = 0; a < 256; a++) begin
            cyc(8'(a), 1'b0, 1'b0, 1'b1, 1'b1, a[2], tag);
            cyc(8'(a), 1'b0, 1'b1, 1'b0, 1'b1, a[3], tag);
            cyc(8'(a), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        end
    endtask

    task automatic count_hits(input int want, input string tag);
        int n = 0;
        for (int a = 0; a < 256; a++) n += int'(ref_match(a));
        checks++;
        if (n != want) begin
            fails++;
            $display("FAIL %s model port count: actual %0d expected %0d", tag, n, want);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = 8'h00; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        m1_n = 1'b1; preset = 2'd0; win = 3'd0; b4m = 2'd0; b3m = 1'b0;
        b21m = 1'b0; to_nmi = 1'b0; irq_n = 1'b1;
        @(negedge clk);
        // Reset with an active, matching read and active interrupt: R10
        addr = 8'h01; iorq_n = 1'b0; rd_n = 1'b0; irq_n = 1'b0;
        @(negedge clk);
        chk("R10", "rd_cs_n", rd_cs_n, 1'b1);
        chk("R10", "wr_cs_n", wr_cs_n, 1'b1);
        chk("R10", "reg_sel", reg_sel, 1'b0);
        chk("R10", "int_n", int_n, 1'b1);
        chk("R10", "nmi_n", nmi_n, 1'b1);
        rst_n = 1'b1;

        // Presets: R9, with exact port counts from the model cross-checked
        preset = 2'd1; count_hits(2, "R9");
        b4m = 2'd1; win = 3'd7; to_nmi = 1'b1;    // custom inputs must not matter
        sweep("R9");
        cyc(8'h98, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
        cyc(8'h99, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        cyc(8'h9A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4");
        preset = 2'd2; count_hits(32, "R9");
        to_nmi = 1'b0; b3m = 1'b1;
        sweep("R9");
        preset = 2'd3; count_hits(16, "R9");
        b21m = 1'b1; to_nmi = 1'b1;
        sweep("R9");

        // Custom settings: all bit-4 modes, bit-3 and low-field modes
        preset = 2'd0; to_nmi = 1'b0;
        win = 3'd3; b3m = 1'b0; b21m = 1'b0;
        for (int m = 0; m < 4; m++) begin
            b4m = 2'(m);
            sweep("R2");
        end
        b4m = 2'd0; win = 3'd6; b3m = 1'b1; sweep("R3");
        b3m = 1'b0; win = 3'd1; b21m = 1'b1; sweep("R4");
        to_nmi = 1'b1; win = 3'd2; b21m = 1'b0; sweep("R1");

        // Idle bus: IORQ high never selects (R5)
        for (int a = 64; a < 96; a++)
            cyc(8'(a), 1'b1, 1'b0, 1'b0, 1'b1, a[0], "R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule